// File: doc/BRIEF.md
# TLB Shootdown Sharer Tracker

This block keeps the translation caches of several cores consistent when the operating system changes a page mapping. It holds a small fully associative table keyed by virtual page number. Each entry records which cores may hold a cached copy of that translation. A core reports each translation it loads through its own fill port, and the tracker sets that core's bit in the matching entry. When the operating system issues a shootdown for a page, the tracker raises an invalidate request only toward the cores recorded for that page. It waits until every one of those cores has acknowledged, then pulses a completion signal and forgets the entry.

Cached translations are read-only metadata, so an entry is either present-and-clean or absent. There is no dirty state, no data travels with an invalidate, and nothing is written back. One shootdown runs at a time. While it runs, `busy` is high and the command port is closed. If a fill names a new page while the table is full, the tracker evicts one entry, chosen round-robin, and invalidates that entry's page on every core before it accepts the fill.

The controller is a three-state machine. IDLE accepts a command (IDLE to WAIT_ACK on an operating-system command) or starts an eviction (IDLE to WAIT_ACK on a full-table miss). WAIT_ACK collects acknowledgements and moves to FINISH once no target is outstanding. FINISH pulses completion for operating-system commands, clears the entry and returns to IDLE.

Top module: `tlb_shootdown_tracker`

## Requirements
- R1: After reset `busy`, `cmd_done` and every `inv_req` bit are 0, and `cmd_ready` is 1.
- R2: A fill accepted from core i for page P sets bit i of P's holder set, and a later shootdown of P raises `inv_req` equal to exactly that set (bit i = core i).
- R3: A shootdown never raises `inv_req` toward a core outside the recorded set, and adds no target after the first WAIT_ACK cycle.
- R4: Each `inv_req` bit stays high until that core's `inv_ack` is sampled, acknowledgements may arrive in any order, and `cmd_done` stays low while any target is outstanding.
- R5: `cmd_done` is a one-cycle pulse in the cycle after the clock edge that samples the last outstanding acknowledgement, and `busy` is low in the cycle after it.
- R6: A shootdown of a page with no entry raises no `inv_req`, and `cmd_done` is high in the second cycle after the command is accepted.
- R7: After a shootdown completes, the page's holder set is empty, so a repeat shootdown with no new fills targets no core.
- R8: While a shootdown or eviction is in progress `busy` is 1 and `cmd_ready` is 0, and an accepted command makes `busy` high on the next cycle.
- R9: A fill for the page under shootdown keeps `fill_ready` low until the controller is back in IDLE, then is accepted.
- R10: A fill for a different page is accepted during a shootdown when it hits an entry or a free entry exists.
- R11: A fill that misses on a full table is held off while the entry at the round-robin victim pointer (starting at entry 0, advancing by one per eviction, entries allocated lowest free index first) is invalidated on all cores with no `cmd_done` pulse; the fill is then accepted and the victim page is untracked.
- R12: Among simultaneous fill requests the lowest-numbered core is served, one fill per cycle, and `fill_ready` is never high for a core without `fill_valid`.
- R13: When a command and a fill are both presented in IDLE, the command is accepted and the fill waits.
- R14: An acknowledgement from a core that is not an outstanding target has no effect on `inv_req`, `busy` or `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill_valid | input | NUM_CORES | Per-core fill notification request |
| fill_vpn | input | NUM_CORES*VPN_W | Per-core page number, core i at bits [i*VPN_W +: VPN_W] |
| fill_ready | output | NUM_CORES | Fill accepted this cycle (at most one bit) |
| cmd_valid | input | 1 | Shootdown command request |
| cmd_vpn | input | VPN_W | Page whose mapping changed |
| cmd_ready | output | 1 | Command port open |
| cmd_done | output | 1 | One-cycle completion pulse for a command |
| inv_req | output | NUM_CORES | Per-core invalidate request, held until acknowledged |
| inv_vpn | output | VPN_W | Page being invalidated |
| inv_ack | input | NUM_CORES | Per-core invalidate acknowledge pulse |
| busy | output | 1 | Shootdown or eviction in progress |

## Verification
The bench builds the tracker with four cores, a four-entry table and 12-bit page numbers. With a table that small, a full-table miss takes only four fills, so the eviction broadcast, the victim pointer and the re-acceptance of the held fill can be driven directly. Four cores are still enough to show a targeted subset, an acknowledgement order that differs from core order, a stray acknowledgement from a non-target core, and a lower-numbered core winning a simultaneous fill.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    typedef enum logic [1:0] {
        SD_IDLE     = 2'd0,
        SD_WAIT_ACK = 2'd1,
        SD_FINISH   = 2'd2
    } sd_state_e;

    typedef enum logic {
        SD_KIND_OS    = 1'b0,
        SD_KIND_EVICT = 1'b1
    } sd_kind_e;

endpackage

// File: rtl/tsd_fill_arb.sv
module tsd_fill_arb #(
    parameter int NUM_CORES = 8,
    parameter int VPN_W     = 20
) (
    input  logic [NUM_CORES-1:0]       req,
    input  logic [NUM_CORES*VPN_W-1:0] req_vpn,
    output logic [NUM_CORES-1:0]       gnt,
    output logic                       gnt_any,
    output logic [VPN_W-1:0]           gnt_vpn
);

    logic [NUM_CORES:0] seen;

    assign seen[0] = 1'b0;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_prio
        assign gnt[c]    = req[c] & ~seen[c];
        assign seen[c+1] = seen[c] | req[c];
    end

    assign gnt_any = seen[NUM_CORES];

    always_comb begin
        gnt_vpn = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (gnt[c]) begin
                gnt_vpn = req_vpn[c*VPN_W +: VPN_W];
            end
        end
    end

endmodule

// File: rtl/tsd_table.sv
module tsd_table #(
    parameter int NUM_CORES   = 8,
    parameter int NUM_ENTRIES = 16,
    parameter int VPN_W       = 20,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    // lookup for fills
    input  logic [VPN_W-1:0]     a_key,
    output logic                 a_hit,
    output logic [IDX_W-1:0]     a_idx,
    // lookup for commands
    input  logic [VPN_W-1:0]     b_key,
    output logic                 b_hit,
    output logic [IDX_W-1:0]     b_idx,
    output logic [NUM_CORES-1:0] b_holders,
    // read port for the victim
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [VPN_W-1:0]     rd_vpn,
    // free slot
    output logic                 free_any,
    output logic [IDX_W-1:0]     free_idx,
    // update
    input  logic                 wr_en,
    input  logic                 wr_alloc,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VPN_W-1:0]     wr_key,
    input  logic [NUM_CORES-1:0] wr_mask,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx
);

    logic                 ent_vld  [NUM_ENTRIES];
    logic [VPN_W-1:0]     ent_vpn  [NUM_ENTRIES];
    logic [NUM_CORES-1:0] ent_hold [NUM_ENTRIES];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_vld[e]  <= 1'b0;
                ent_vpn[e]  <= '0;
                ent_hold[e] <= '0;
            end else if (clr_en && clr_idx == IDX_W'(e)) begin
                ent_vld[e]  <= 1'b0;
                ent_hold[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                if (wr_alloc) begin
                    ent_vld[e]  <= 1'b1;
                    ent_vpn[e]  <= wr_key;
                    ent_hold[e] <= wr_mask;
                end else begin
                    ent_hold[e] <= ent_hold[e] | wr_mask;
                end
            end
        end
    end

    always_comb begin
        a_hit = 1'b0;
        a_idx = '0;
        b_hit = 1'b0;
        b_idx = '0;
        b_holders = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (ent_vld[e] && ent_vpn[e] == a_key) begin
                a_hit = 1'b1;
                a_idx = IDX_W'(e);
            end
            if (ent_vld[e] && ent_vpn[e] == b_key) begin
                b_hit     = 1'b1;
                b_idx     = IDX_W'(e);
                b_holders = ent_hold[e];
            end
        end
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
            if (!ent_vld[e]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(e);
            end
        end
    end

    always_comb begin
        rd_vpn = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (rd_idx == IDX_W'(e)) begin
                rd_vpn = ent_vpn[e];
            end
        end
    end

endmodule

// File: rtl/tsd_ctrl.sv
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int NUM_CORES   = 8,
    parameter int NUM_ENTRIES = 16,
    parameter int VPN_W       = 20,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_fire,
    input  logic [VPN_W-1:0]     cmd_vpn,
    input  logic                 cmd_hit,
    input  logic [IDX_W-1:0]     cmd_idx,
    input  logic [NUM_CORES-1:0] cmd_holders,
    input  logic                 evict_fire,
    input  logic [VPN_W-1:0]     victim_vpn,
    input  logic [NUM_CORES-1:0] inv_ack,
    output logic [IDX_W-1:0]     victim_ptr,
    output logic [NUM_CORES-1:0] inv_req,
    output logic [VPN_W-1:0]     act_vpn,
    output logic                 busy,
    output logic                 done,
    output logic                 clr_en,
    output logic [IDX_W-1:0]     clr_idx
);

    sd_state_e            state_q, state_d;
    sd_kind_e             kind_q;
    logic [NUM_CORES-1:0] pend_q;
    logic [IDX_W-1:0]     act_idx_q;
    logic                 act_hit_q;
    logic [IDX_W-1:0]     vptr_q;
    logic [NUM_CORES-1:0] pend_left;

    assign pend_left = pend_q & ~inv_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_IDLE: begin
                if (cmd_fire || evict_fire) begin
                    state_d = SD_WAIT_ACK;
                end
            end
            SD_WAIT_ACK: begin
                if (pend_left == '0) begin
                    state_d = SD_FINISH;
                end
            end
            SD_FINISH: begin
                state_d = SD_IDLE;
            end
            default: begin
                state_d = SD_IDLE;
            end
        endcase
    end

    // transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= SD_KIND_OS;
            pend_q    <= '0;
            act_vpn   <= '0;
            act_idx_q <= '0;
            act_hit_q <= 1'b0;
            vptr_q    <= '0;
        end else begin
            unique case (state_q)
                SD_IDLE: begin
                    if (cmd_fire) begin
                        kind_q    <= SD_KIND_OS;
                        pend_q    <= cmd_hit ? cmd_holders : '0;
                        act_vpn   <= cmd_vpn;
                        act_idx_q <= cmd_idx;
                        act_hit_q <= cmd_hit;
                    end else if (evict_fire) begin
                        kind_q    <= SD_KIND_EVICT;
                        pend_q    <= '1;
                        act_vpn   <= victim_vpn;
                        act_idx_q <= vptr_q;
                        act_hit_q <= 1'b1;
                        if (vptr_q == IDX_W'(NUM_ENTRIES - 1)) begin
                            vptr_q <= '0;
                        end else begin
                            vptr_q <= vptr_q + 1'b1;
                        end
                    end
                end
                SD_WAIT_ACK: begin
                    pend_q <= pend_left;
                end
                SD_FINISH: begin
                    act_hit_q <= 1'b0;
                end
                default: begin
                    pend_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        inv_req = '0;
        busy    = 1'b1;
        done    = 1'b0;
        clr_en  = 1'b0;
        unique case (state_q)
            SD_IDLE: begin
                busy = 1'b0;
            end
            SD_WAIT_ACK: begin
                inv_req = pend_q;
            end
            SD_FINISH: begin
                done   = (kind_q == SD_KIND_OS);
                clr_en = act_hit_q;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

    assign clr_idx    = act_idx_q;
    assign victim_ptr = vptr_q;

endmodule

// File: rtl/tlb_shootdown_tracker.sv
module tlb_shootdown_tracker #(
    parameter int NUM_CORES   = 8,
    parameter int NUM_ENTRIES = 16,
    parameter int VPN_W       = 20,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       fill_valid,
    input  logic [NUM_CORES*VPN_W-1:0] fill_vpn,
    output logic [NUM_CORES-1:0]       fill_ready,
    input  logic                       cmd_valid,
    input  logic [VPN_W-1:0]           cmd_vpn,
    output logic                       cmd_ready,
    output logic                       cmd_done,
    output logic [NUM_CORES-1:0]       inv_req,
    output logic [VPN_W-1:0]           inv_vpn,
    input  logic [NUM_CORES-1:0]       inv_ack,
    output logic                       busy
);

    logic [NUM_CORES-1:0] gnt;
    logic                 gnt_any;
    logic [VPN_W-1:0]     gnt_vpn;

    logic                 a_hit, b_hit, free_any;
    logic [IDX_W-1:0]     a_idx, b_idx, free_idx;
    logic [NUM_CORES-1:0] b_holders;
    logic [VPN_W-1:0]     rd_vpn;
    logic [IDX_W-1:0]     victim_ptr;

    logic                 clr_en;
    logic [IDX_W-1:0]     clr_idx;
    logic                 cmd_fire, evict_fire, fill_ok;
    logic                 fill_blocked;

    tsd_fill_arb #(
        .NUM_CORES (NUM_CORES),
        .VPN_W     (VPN_W)
    ) u_arb (
        .req     (fill_valid),
        .req_vpn (fill_vpn),
        .gnt     (gnt),
        .gnt_any (gnt_any),
        .gnt_vpn (gnt_vpn)
    );

    // command wins over a fill in IDLE; the page under shootdown is held off
    assign fill_blocked = (!busy && cmd_valid) || (busy && gnt_vpn == inv_vpn);
    assign fill_ok      = gnt_any && !fill_blocked && (a_hit || free_any);
    assign evict_fire   = gnt_any && !busy && !cmd_valid && !a_hit && !free_any;
    assign cmd_fire     = cmd_valid && !busy;
    assign cmd_ready    = !busy;
    assign fill_ready   = fill_ok ? gnt : '0;

    tsd_table #(
        .NUM_CORES   (NUM_CORES),
        .NUM_ENTRIES (NUM_ENTRIES),
        .VPN_W       (VPN_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_key     (gnt_vpn),
        .a_hit     (a_hit),
        .a_idx     (a_idx),
        .b_key     (cmd_vpn),
        .b_hit     (b_hit),
        .b_idx     (b_idx),
        .b_holders (b_holders),
        .rd_idx    (victim_ptr),
        .rd_vpn    (rd_vpn),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .wr_en     (fill_ok),
        .wr_alloc  (!a_hit),
        .wr_idx    (a_hit ? a_idx : free_idx),
        .wr_key    (gnt_vpn),
        .wr_mask   (gnt),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    tsd_ctrl #(
        .NUM_CORES   (NUM_CORES),
        .NUM_ENTRIES (NUM_ENTRIES),
        .VPN_W       (VPN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_fire    (cmd_fire),
        .cmd_vpn     (cmd_vpn),
        .cmd_hit     (b_hit),
        .cmd_idx     (b_idx),
        .cmd_holders (b_holders),
        .evict_fire  (evict_fire),
        .victim_vpn  (rd_vpn),
        .inv_ack     (inv_ack),
        .victim_ptr  (victim_ptr),
        .inv_req     (inv_req),
        .act_vpn     (inv_vpn),
        .busy        (busy),
        .done        (cmd_done),
        .clr_en      (clr_en),
        .clr_idx     (clr_idx)
    );

endmodule

// File: rtl/tlb_shootdown_tracker_chk.sv
module tlb_shootdown_tracker_chk #(
    parameter int NUM_CORES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] fill_valid,
    input logic [NUM_CORES-1:0] fill_ready,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 cmd_done,
    input logic [NUM_CORES-1:0] inv_req,
    input logic [NUM_CORES-1:0] inv_ack,
    input logic                 busy
);

    assert_inv_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req != '0) |-> busy);

    assert_no_new_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((inv_req & ~$past(inv_req)) == '0));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_req[c] && !inv_ack[c]) |=> inv_req[c]);
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (!cmd_done && !busy));

    assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (inv_req == '0));

    assert_cmd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    assert_fill_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_ready));

    assert_fill_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_ready & ~fill_valid) == '0));

endmodule

bind tlb_shootdown_tracker tlb_shootdown_tracker_chk #(
    .NUM_CORES (NUM_CORES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_done   (cmd_done),
    .inv_req    (inv_req),
    .inv_ack    (inv_ack),
    .busy       (busy)
);

// File: tb/tlb_shootdown_tracker_bench.sv
`timescale 1ns/1ps
module tlb_shootdown_tracker_bench;

    localparam int NC = 4;
    localparam int NE = 4;
    localparam int VW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     fill_valid = '0;
    logic [NC*VW-1:0]  fill_vpn = '0;
    logic [NC-1:0]     fill_ready;
    logic              cmd_valid = 1'b0;
    logic [VW-1:0]     cmd_vpn = '0;
    logic              cmd_ready, cmd_done, busy;
    logic [NC-1:0]     inv_req;
    logic [VW-1:0]     inv_vpn;
    logic [NC-1:0]     inv_ack = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tlb_shootdown_tracker #(
        .NUM_CORES   (NC),
        .NUM_ENTRIES (NE),
        .VPN_W       (VW)
    ) u_tlb_shootdown_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_vpn   (fill_vpn),
        .fill_ready (fill_ready),
        .cmd_valid  (cmd_valid),
        .cmd_vpn    (cmd_vpn),
        .cmd_ready  (cmd_ready),
        .cmd_done   (cmd_done),
        .inv_req    (inv_req),
        .inv_vpn    (inv_vpn),
        .inv_ack    (inv_ack),
        .busy       (busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input int c, input logic [VW-1:0] v, input string req);
        @(negedge clk);
        fill_valid[c] = 1'b1;
        fill_vpn[c*VW +: VW] = v;
        #1;
        chk(req, "fill accepted", 32'(fill_ready), 32'(1 << c));
        @(negedge clk);
        fill_valid[c] = 1'b0;
        #1;
    endtask

    task automatic start_cmd(input logic [VW-1:0] v);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_vpn = v;
        #1;
        chk("R8", "cmd_ready idle", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic ack_mask(input logic [NC-1:0] m);
        inv_ack = m;
        @(negedge clk);
        inv_ack = '0;
        #1;
    endtask

    task automatic run_sd(input logic [VW-1:0] v, input logic [NC-1:0] exp, input string req);
        start_cmd(v);
        chk(req, "inv_req targets", 32'(inv_req), 32'(exp));
        chk(req, "inv_vpn", 32'(inv_vpn), 32'(v));
        if (exp != '0) ack_mask(exp);
        else begin @(negedge clk); #1; end
        chk("R5", "done pulse", 32'(cmd_done), 32'd1);
        @(negedge clk);
        #1;
        chk("R5", "done low after", 32'(cmd_done), 32'd0);
        chk("R5", "busy low after", 32'(busy), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(cmd_done), 32'd0);
        chk("R1", "inv_req", 32'(inv_req), 32'd0);
        chk("R1", "cmd_ready", 32'(cmd_ready), 32'd1);
    endtask

    task automatic t_basic;
        do_fill(0, 12'h011, "R2");
        do_fill(2, 12'h011, "R2");
        do_fill(3, 12'h022, "R2");
        run_sd(12'h011, 4'b0101, "R2");
        run_sd(12'h011, 4'b0000, "R7");
        run_sd(12'h022, 4'b1000, "R3");
    endtask

    task automatic t_order;
        do_fill(0, 12'h033, "R2");
        do_fill(1, 12'h033, "R2");
        start_cmd(12'h033);
        chk("R3", "targets", 32'(inv_req), 32'b0011);
        chk("R8", "busy", 32'(busy), 32'd1);
        chk("R8", "cmd_ready busy", 32'(cmd_ready), 32'd0);
        ack_mask(4'b0010);
        chk("R4", "remaining", 32'(inv_req), 32'b0001);
        chk("R4", "no early done", 32'(cmd_done), 32'd0);
        ack_mask(4'b1000);
        chk("R14", "stray ack req", 32'(inv_req), 32'b0001);
        chk("R14", "stray ack busy", 32'(busy), 32'd1);
        chk("R14", "stray ack done", 32'(cmd_done), 32'd0);
        ack_mask(4'b0001);
        chk("R5", "done after last", 32'(cmd_done), 32'd1);
        @(negedge clk);
        #1;
        chk("R5", "idle after", 32'(busy), 32'd0);
    endtask

    task automatic t_untracked;
        start_cmd(12'h077);
        chk("R6", "no targets", 32'(inv_req), 32'd0);
        chk("R6", "no done yet", 32'(cmd_done), 32'd0);
        @(negedge clk);
        #1;
        chk("R6", "done second cycle", 32'(cmd_done), 32'd1);
        @(negedge clk);
        #1;
    endtask

    task automatic t_holdoff;
        do_fill(0, 12'h044, "R2");
        do_fill(1, 12'h044, "R2");
        start_cmd(12'h044);
        chk("R3", "targets", 32'(inv_req), 32'b0011);
        fill_valid[3] = 1'b1;
        fill_vpn[3*VW +: VW] = 12'h044;
        #1;
        chk("R9", "held fill", 32'(fill_ready), 32'd0);
        fill_valid[2] = 1'b1;
        fill_vpn[2*VW +: VW] = 12'h045;
        #1;
        chk("R10", "other page fill", 32'(fill_ready), 32'b0100);
        @(negedge clk);
        fill_valid[2] = 1'b0;
        #1;
        chk("R9", "still held", 32'(fill_ready), 32'd0);
        ack_mask(4'b0011);
        chk("R5", "done", 32'(cmd_done), 32'd1);
        chk("R9", "held in finish", 32'(fill_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R9", "released in idle", 32'(fill_ready), 32'b1000);
        @(negedge clk);
        fill_valid[3] = 1'b0;
        #1;
        run_sd(12'h044, 4'b1000, "R9");
        run_sd(12'h045, 4'b0100, "R10");
    endtask

    task automatic t_simul;
        @(negedge clk);
        fill_valid[0] = 1'b1;
        fill_valid[2] = 1'b1;
        fill_vpn[0 +: VW] = 12'h055;
        fill_vpn[2*VW +: VW] = 12'h055;
        #1;
        chk("R12", "lowest first", 32'(fill_ready), 32'b0001);
        @(negedge clk);
        fill_valid[0] = 1'b0;
        #1;
        chk("R12", "next core", 32'(fill_ready), 32'b0100);
        @(negedge clk);
        fill_valid[2] = 1'b0;
        #1;
        run_sd(12'h055, 4'b0101, "R12");
    endtask

    task automatic t_priority;
        @(negedge clk);
        fill_valid[0] = 1'b1;
        fill_vpn[0 +: VW] = 12'h066;
        cmd_valid = 1'b1;
        cmd_vpn = 12'h067;
        #1;
        chk("R13", "fill waits", 32'(fill_ready), 32'd0);
        chk("R13", "cmd taken", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R10", "fill during sd", 32'(fill_ready), 32'b0001);
        @(negedge clk);
        fill_valid[0] = 1'b0;
        #1;
        chk("R6", "done", 32'(cmd_done), 32'd1);
        @(negedge clk);
        #1;
        run_sd(12'h066, 4'b0001, "R13");
    endtask

    task automatic t_evict;
        for (int p = 0; p < NE; p++) do_fill(0, VW'(12'h100 + p), "R11");
        @(negedge clk);
        fill_valid[1] = 1'b1;
        fill_vpn[1*VW +: VW] = 12'h104;
        #1;
        chk("R11", "miss full held", 32'(fill_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R11", "broadcast", 32'(inv_req), 32'b1111);
        chk("R11", "victim page", 32'(inv_vpn), 32'h100);
        chk("R8", "evict busy", 32'(cmd_ready), 32'd0);
        ack_mask(4'b1111);
        chk("R11", "no done on evict", 32'(cmd_done), 32'd0);
        chk("R11", "fill held finish", 32'(fill_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R11", "fill after evict", 32'(fill_ready), 32'b0010);
        @(negedge clk);
        fill_valid[1] = 1'b0;
        #1;
        run_sd(12'h100, 4'b0000, "R11");
        run_sd(12'h104, 4'b0010, "R11");
        for (int p = 1; p < NE; p++) run_sd(VW'(12'h100 + p), 4'b0001, "R11");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_basic();
        t_order();
        t_untracked();
        t_holdoff();
        t_simul();
        t_priority();
        t_evict();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule